// File: doc/BRIEF.md
# Reservation monitor for load-locked / store-conditional

This block keeps the single address reservation that one processor uses for lock-free synchronisation. A load-locked request stores the word address it touched and arms the reservation. Every write made by any processor in the system is broadcast on a snoop bus. A broadcast write to the reserved word disarms the reservation.

A store-conditional request is checked against the reservation. The check passes only when the reservation is armed, the store targets the reserved word and no matching snooped write is seen in the same cycle. If the check passes, the store goes on to memory. If it fails, the store is dropped. Either way the block reports the new N, Z, V and C flag values: N, Z and C are always zero, and V is one when the store failed. Every store-conditional ends the reservation.

The block does not carry the loaded data or work out the flags for the load. It does not arbitrate the bus.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the reservation is disarmed (`armed`=0), `sc_done`=0 and `mem_wr_valid`=0. A store-conditional issued before any load-locked fails.
- R2: A store-conditional to the word named by the last load-locked, with no cancelling write in between, succeeds. One cycle after the request, `sc_done`=1, `mem_wr_valid`=1, `mem_wr_addr`/`mem_wr_data` equal the request's address and data, and `nzvc`=4'b0000.
- R3: A valid snooped write to the reserved word disarms the reservation. A later store-conditional to that word fails: `sc_done`=1, `mem_wr_valid`=0 and `nzvc`=4'b0010 (bit 3 N, bit 2 Z, bit 1 V, bit 0 C).
- R4: A snooped write to a different word leaves the reservation armed.
- R5: All address comparisons use bits [ADDR_W-1:2] only. The two low bits are ignored for the load-locked, the store-conditional and the snooped addresses.
- R6: A store-conditional whose word differs from the reserved word fails.
- R7: A new load-locked replaces any earlier reservation. A store-conditional to the earlier word then fails.
- R8: Every store-conditional, whether it passes or fails, disarms the reservation, so a second store-conditional with no new load-locked fails.
- R9: A store-conditional checked in the same cycle as a snooped write to the reserved word fails. A snooped write to another word in that cycle does not affect the result.
- R10: A load-locked has priority over a store-conditional or a snooped write in the same cycle. The store-conditional is checked against the old reservation, and the new reservation is armed afterwards.
- R11: `mem_wr_valid` is never asserted without `sc_done`, and a failed store-conditional never produces a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-locked request |
| ll_addr | input | ADDR_W | Load-locked byte address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_data | input | DATA_W | Store-conditional data |
| snoop_valid | input | 1 | Broadcast write seen on the system bus |
| snoop_addr | input | ADDR_W | Byte address of the broadcast write |
| mem_wr_valid | output | 1 | Forwarded store to memory |
| mem_wr_addr | output | ADDR_W | Forwarded store address |
| mem_wr_data | output | DATA_W | Forwarded store data |
| sc_done | output | 1 | Store-conditional result is valid |
| nzvc | output | 4 | New flags {N,Z,V,C} for the store-conditional |
| armed | output | 1 | Reservation is currently held |

## Verification
A store-conditional result (`sc_done`, `nzvc` and the forwarded write) appears one clock edge after the request. The reservation state on `armed` also changes at the first edge after a load-locked, store-conditional or snooped write. The bench drives each request for one cycle starting on a falling edge. At the same time it pushes the predicted result into a scoreboard queue. A monitor compares the outputs on the next falling edge, half a cycle after the registers update, so each result is checked in exactly the cycle it is due and never at the active edge.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [DATA_W-1:0] sc_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              sc_done,
  output logic [3:0]        nzvc,
  output logic              armed
);
  localparam int LSB   = 2;
  localparam int TAG_W = ADDR_W - LSB;

  logic [TAG_W-1:0] lock_tag;
  logic             held;
  logic             fail_q;

  wire snoop_hit = snoop_valid && (snoop_addr[ADDR_W-1:LSB] == lock_tag);
  wire sc_match  = sc_addr[ADDR_W-1:LSB] == lock_tag;
  wire sc_ok     = sc_valid && held && sc_match && !snoop_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      lock_tag <= '0;
    end else if (ll_valid) begin
      held     <= 1'b1;
      lock_tag <= ll_addr[ADDR_W-1:LSB];
    end else if (sc_valid || snoop_hit) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      sc_done      <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      mem_wr_valid <= sc_ok;
      sc_done      <= sc_valid;
      fail_q       <= sc_valid && !sc_ok;
      if (sc_valid) begin
        mem_wr_addr <= sc_addr;
        mem_wr_data <= sc_data;
      end
    end
  end

  assign nzvc  = {2'b00, fail_q, 1'b0};
  assign armed = held;

  // R11
  wr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> sc_done);

  // R3
  v_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> (nzvc[1] != mem_wr_valid));

  // R8
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !ll_valid) |=> !armed);

  // R10
  ll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll_valid |=> armed);

  // R1
  unarmed_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !armed) |=> (sc_done && !mem_wr_valid));

  // R9
  race_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && snoop_valid && sc_addr[ADDR_W-1:LSB] == snoop_addr[ADDR_W-1:LSB])
      |=> !mem_wr_valid);
endmodule

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ll_valid = 1'b0, sc_valid = 1'b0, snoop_valid = 1'b0;
  logic [31:0] ll_addr = '0, sc_addr = '0, sc_data = '0, snoop_addr = '0;
  logic        mem_wr_valid, sc_done, armed;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  nzvc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        q_ok[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .sc_done(sc_done), .nzvc(nzvc), .armed(armed)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_valid && !sc_done) begin
        checks++; fails++;
        $display("FAIL R11: mem_wr_valid=1 with sc_done=0 (expected no write)");
      end
      if (sc_done) begin
        checks++;
        if (q_ok.size() == 0) begin
          fails++;
          $display("FAIL R11: unexpected sc_done=1, expected none");
        end else begin
          logic ok; logic [31:0] a; logic [31:0] d; string t;
          ok = q_ok.pop_front(); a = q_addr.pop_front();
          d = q_data.pop_front(); t = q_tag.pop_front();
          if (mem_wr_valid !== ok || nzvc !== (ok ? 4'b0000 : 4'b0010) ||
              (ok && (mem_wr_addr !== a || mem_wr_data !== d))) begin
            fails++;
            $display("FAIL %s: wr=%b nzvc=%b addr=%h data=%h expected wr=%b nzvc=%b addr=%h data=%h",
                     t, mem_wr_valid, nzvc, mem_wr_addr, mem_wr_data,
                     ok, ok ? 4'b0000 : 4'b0010, a, d);
          end
        end
      end
    end
  end

  task automatic step(input bit ll, input logic [31:0] la,
                      input bit sc, input logic [31:0] sa, input logic [31:0] sd,
                      input bit sn, input logic [31:0] na,
                      input bit exp_ok, input string tag);
    ll_valid = ll; ll_addr = la;
    sc_valid = sc; sc_addr = sa; sc_data = sd;
    snoop_valid = sn; snoop_addr = na;
    if (sc) begin
      q_ok.push_back(exp_ok); q_addr.push_back(sa);
      q_data.push_back(sd); q_tag.push_back(tag);
    end
    @(negedge clk);
    ll_valid = 1'b0; sc_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic ll(input logic [31:0] a);
    step(1, a, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic sc(input logic [31:0] a, input logic [31:0] d, input bit ok, input string tag);
    step(0, 0, 1, a, d, 0, 0, ok, tag);
  endtask
  task automatic snoop(input logic [31:0] a);
    step(0, 0, 0, 0, 0, 1, a, 0, "");
  endtask
  task automatic chk_armed(input bit e, input string tag);
    checks++;
    if (armed !== e) begin
      fails++;
      $display("FAIL %s: armed=%b expected %b", tag, armed, e);
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (armed !== 1'b0 || sc_done !== 1'b0 || mem_wr_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: armed=%b sc_done=%b wr=%b expected 0 0 0", armed, sc_done, mem_wr_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    sc(32'h100, 32'hAAAA_0001, 0, "R1");
    ll(32'h100); chk_armed(1, "R2");
    sc(32'h100, 32'hAAAA_0002, 1, "R2");
    chk_armed(0, "R8");
    sc(32'h100, 32'hAAAA_0003, 0, "R8");

    ll(32'h200); snoop(32'h200); chk_armed(0, "R3");
    sc(32'h200, 32'hBBBB_0001, 0, "R3");

    ll(32'h300); snoop(32'h304); chk_armed(1, "R4");
    sc(32'h300, 32'hBBBB_0002, 1, "R4");

    ll(32'h401);
    sc(32'h402, 32'hCCCC_0001, 1, "R5");
    ll(32'h500); snoop(32'h503); chk_armed(0, "R5");
    sc(32'h500, 32'hCCCC_0002, 0, "R5");

    ll(32'h600);
    sc(32'h604, 32'hDDDD_0001, 0, "R6");

    ll(32'h700); ll(32'h800);
    sc(32'h700, 32'hEEEE_0001, 0, "R7");
    ll(32'h700); ll(32'h800);
    sc(32'h800, 32'hEEEE_0002, 1, "R7");

    ll(32'h900);
    step(0, 0, 1, 32'h900, 32'h1111_0001, 1, 32'h902, 0, "R9");
    ll(32'h900);
    step(0, 0, 1, 32'h900, 32'h1111_0002, 1, 32'h980, 1, "R9");

    ll(32'hA00);
    step(1, 32'hB00, 1, 32'hA00, 32'h2222_0001, 0, 0, 1, "R10");
    chk_armed(1, "R10");
    sc(32'hB00, 32'h2222_0002, 1, "R10");
    step(1, 32'hC00, 0, 0, 0, 1, 32'hC00, 0, "");
    chk_armed(1, "R10");
    sc(32'hC00, 32'h2222_0003, 1, "R10");

    repeat (2) @(negedge clk);
    checks++;
    if (q_ok.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d results missing, expected 0", q_ok.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule